// File: doc/BRIEF.md
# Mode-Selectable Event Flip-Flop Stage

This block sits behind a pair of event expressions, e0 and e1, and turns them into two complementary event outputs through one storage element. A three-bit mode input decides how the two inputs are read. They can pass straight through, act as a reset/set pair, act as a toggle with its clock, act as data with a clock, or act as data with a level enable. A JK element is made by running the D path while the stored value goes out on a feedback port to the expression logic, which returns J&~Q | ~K&Q on e0.

Everything runs on one system clock. The e1 input is never used as a real clock. It is sampled, and a rising edge is a cycle in which e1 is high when it was low on the previous system clock. A one-cycle force request loads a programmed initial value into the stored bit. The expression logic and any glitch filtering sit outside this block.

Top module: `evt_ff_stage`

## Requirements
- R1: After reset the stored bit is 0, so in any storage mode outa is 0 and outb is 1. The previous-e1 register also resets to 0.
- R2: Mode codes 0, 6 and 7 are bypass. In bypass, outa equals e0 and outb equals e1 with no register in the path, and the stored bit keeps its value unless a force request arrives.
- R3: Mode 1 is reset/set. On each clock, e0 high clears the stored bit whatever e1 is. If e0 is low, e1 high sets the bit. If both are low, the bit holds.
- R4: Mode 2 is toggle. The stored bit inverts on a clock where e1 rises and e0 is high. In every other case it holds.
- R5: Mode 3 is D. The stored bit takes e0 on a clock where e1 rises, and holds otherwise. A rise means e1 is 1 now and was 0 at the previous clock.
- R6: Mode 4 is JK. It updates exactly as mode 3, and fb_q always carries the stored bit, so a J&~Q | ~K&Q expression fed back on e0 gives JK behaviour.
- R7: Mode 5 is latch. On each clock where e1 is high the stored bit takes e0. While e1 is low it holds.
- R8: In modes 1 to 5, outa is the stored bit and outb is its complement.
- R9: When force_init is high on a clock, the stored bit takes init_val on that edge. This happens in every mode and overrides the mode's own update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Element behaviour select (0 bypass, 1 reset/set, 2 toggle, 3 D, 4 JK, 5 latch, others bypass) |
| e0 | input | 1 | First expression result (reset, T or data) |
| e1 | input | 1 | Second expression result (set, sampled clock or enable) |
| force_init | input | 1 | Load init_val into the stored bit on this clock |
| init_val | input | 1 | Programmed initial value |
| outa | output | 1 | Primary event output |
| outb | output | 1 | Secondary event output (complement of outa when storing) |
| fb_q | output | 1 | Stored bit, fed back to the expression logic for JK use |

## Verification
A wrong stored bit shows on outa and outb, and on fb_q, on the clock edge after the stimulus that caused it, in every storage mode. A bit that went wrong while the block was in bypass stays hidden at outa until the mode returns to a storage code. For this reason the bench leaves bypass by way of a non-updating clock and then reads the held value. A faulty previous-e1 register shows up as an extra or missing toggle or capture one clock after e1 has been high for two or more cycles.

// File: rtl/evt_ff_stage.sv
module evt_ff_stage #(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              e0,
  input  logic              e1,
  input  logic              force_init,
  input  logic              init_val,
  output logic              outa,
  output logic              outb,
  output logic              fb_q
);
  localparam logic [MODE_W-1:0] M_RS    = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_TOG   = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_D     = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_JK    = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_LATCH = MODE_W'(5);

  logic q, e1_d, q_nxt;
  logic rise, storing;

  assign rise    = e1 & ~e1_d;
  assign storing = (mode >= M_RS) && (mode <= M_LATCH);

  always_comb begin
    q_nxt = q;
    unique case (mode)
      M_RS:       if (e0) q_nxt = 1'b0; else if (e1) q_nxt = 1'b1;
      M_TOG:      if (rise && e0) q_nxt = ~q;
      M_D, M_JK:  if (rise) q_nxt = e0;
      M_LATCH:    if (e1) q_nxt = e0;
      default:    q_nxt = q;
    endcase
    if (force_init) q_nxt = init_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= 1'b0;
      e1_d <= 1'b0;
    end else begin
      q    <= q_nxt;
      e1_d <= e1;
    end
  end

  assign outa = storing ? q  : e0;
  assign outb = storing ? ~q : e1;
  assign fb_q = q;
endmodule

// File: rtl/evt_ff_stage_chk.sv
module evt_ff_stage_chk #(
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode,
  input logic              e0,
  input logic              e1,
  input logic              force_init,
  input logic              init_val,
  input logic              outa,
  input logic              outb,
  input logic              fb_q
);
  logic store_m;
  assign store_m = (mode != '0) && (mode <= MODE_W'(5));

  a_r8_complement: assert property (@(posedge clk) disable iff (!rst_n)
    store_m |-> (outb == ~outa));

  a_r9_force_load: assert property (@(posedge clk) disable iff (!rst_n)
    force_init |=> (fb_q == $past(init_val)));

  a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_W'(1) && e0 && !force_init) |=> (fb_q == 1'b0));

  a_r2_bypass_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_m && !force_init) |=> $stable(fb_q));

  a_r6_feedback: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_W'(4)) |-> (fb_q == outa));

  a_r5_no_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_W'(3) && !e1 && !force_init) |=> $stable(fb_q));

  a_r7_latch_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_W'(5) && !e1 && !force_init) |=> $stable(fb_q));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (fb_q == 1'b0));
endmodule

bind evt_ff_stage evt_ff_stage_chk #(.MODE_W(MODE_W)) chk (.*);

// File: tb/evt_ff_stage_test.sv
module evt_ff_stage_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd1;
  logic e0 = 1'b0, e1 = 1'b0, force_init = 1'b0, init_val = 1'b0;
  logic outa, outb, fb_q;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_ff_stage uut (.clk(clk), .rst_n(rst_n), .mode(mode), .e0(e0), .e1(e1),
    .force_init(force_init), .init_val(init_val),
    .outa(outa), .outb(outb), .fb_q(fb_q));

  // mode[8:6] e0[5] e1[4] force[3] init[2] exp_outa[1] exp_outb[0]
  localparam int NV = 29;
  localparam logic [8:0] VEC [NV] = '{
    9'b001_0100_10, 9'b001_1100_01, 9'b001_0000_01, 9'b001_0100_10, // R3
    9'b001_0000_10, 9'b010_1100_01, 9'b010_1100_01, 9'b010_1000_01, // R4
    9'b010_1100_10, 9'b010_0000_10, 9'b010_0100_10, 9'b011_0100_10, // R4 R5
    9'b011_0000_10, 9'b011_0100_01, 9'b011_1100_01, 9'b101_1100_10, // R5 R7
    9'b101_0100_01, 9'b101_1000_01, 9'b101_1011_10, 9'b011_0111_10, // R7 R9
    9'b000_1000_10, 9'b000_0000_00, 9'b000_0100_01, 9'b011_0100_10, // R2
    9'b111_1000_10, 9'b111_0100_01, 9'b010_1100_10, 9'b000_1110_11, // R2 R9
    9'b001_0000_01                                                 // R9
  };

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outa/outb=%b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", {outa, outb}, 2'b01);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {mode, e0, e1, force_init, init_val} = VEC[i][8:2];
      @(posedge clk); #1;
      chk($sformatf("R2..R9 vector %0d (R8)", i), {outa, outb}, VEC[i][1:0]);
    end

    // R6: JK by feedback J&~Q | ~K&Q, J=K=1 toggles, J=1 K=0 sets
    @(negedge clk);
    force_init = 1'b0; mode = 3'd4; e1 = 1'b0; e0 = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic exp_q;
      @(negedge clk);
      exp_q = ~fb_q;
      e0 = exp_q; e1 = 1'b1;
      @(posedge clk); #1;
      chk("R6 toggle", {outa, fb_q}, {exp_q, exp_q});
      @(negedge clk) e1 = 1'b0;
      @(posedge clk); #1;
    end
    @(negedge clk); e0 = 1'b1; e1 = 1'b1;
    @(posedge clk); #1;
    chk("R6 set", {outa, outb}, 2'b10);

    // R1: reset mid-run clears stored bit
    @(negedge clk); rst_n = 1'b0; mode = 3'd1; e0 = 1'b0; e1 = 1'b0;
    @(posedge clk); #1;
    chk("R1 rerun", {outa, outb}, 2'b01);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 hold", {outa, fb_q}, 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule